// File: doc/BRIEF.md
# Display Bus Write Controller

A register-programmed engine that pushes words from a transmit FIFO onto a parallel bus to a smart display panel. Each bus cycle presents one word, drives an active-low write strobe for a programmed number of ticks, then holds the strobe high for a second programmed number of ticks. A tick is one period of a functional clock, which is the input clock divided by an integer from 1 to 8. A command/data select line travels with each word.

Software programs the divider, both strobe phases and a cycle count, loads words through a FIFO port, then clears a stop bit to launch the transfer. The engine emits exactly the programmed number of cycles. It pauses whenever the FIFO runs dry, and it reports idle once the count is used up. An identification register plays back a fixed sync pattern, a component code and a version word, so software can confirm the block is present.

Register word addresses on `reg_addr`: 0 identification, 1 control, 2 timing, 3 cycle count, 4 pick, 5 FIFO (write only), 6 status. Reads return data in `reg_rdata` one clock after `reg_rd`.

Top module: `dbus_wr_ctrl`

## Requirements
- R1: A write to address 0 rewinds the identification sequence. The following reads of address 0 return 0x55555555, then 0xAAAAAAAA, then the component code, then the version word (major number in bits 31:16, minor in 15:0). Any further reads keep returning the version word.
- R2: Timing bits 2:0 hold the divisor minus one (0..7). The functional tick occurs once every (field+1) input clocks.
- R3: Timing bits 7:4 (TW0) set the strobe low time of every bus cycle to TW0+1 ticks, at most 16.
- R4: Timing bits 13:8 (TW1) set the strobe high time between back-to-back cycles of one transfer to TW1+1 ticks, at most 64.
- R5: Count bits 17:0 hold the number of bus cycles minus one. A transfer emits exactly that many plus one cycles. Words left in the FIFO are not sent.
- R6: Control bit 3 selects command (0) or data (1). `bus_dc` takes its value at the start of each cycle.
- R7: Words leave in FIFO order. `bus_data` and `bus_dc` stay stable while the strobe is low.
- R8: Control bit 2 (stop, set at reset) holds the engine with no new cycles. A control write that clears a set stop bit loads the count and starts a transfer.
- R9: Control bit 1 (soft reset) empties the FIFO, ends any transfer and holds the strobe high. Control bit 0 (enable) must be 1 for ticks to run.
- R10: Status (address 6) bit 0 is 1 when no transfer is in progress, bit 1 is 1 when the FIFO is empty, and bit 2 is 1 when it is full. After reset the status reads 0x3 and control reads 0x4.
- R11: A transfer whose FIFO runs empty waits, still busy, and continues when words arrive. No word is taken from an empty FIFO.
- R12: Pick bits 4:0 hold width minus one and bits 9:5 hold count minus one. Pick, timing and count registers read back what was written, in their own field positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the clock after `reg_rd` |
| bus_data | output | DW | Panel data bus |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dc | output | 1 | Command (0) / data (1) select |

## Verification
The bench measures the strobe low and high widths in input clocks under several divider and phase settings, including the largest ones. A wrong divider or an off-by-one phase counter shows up as a width mismatch, and an extra idle tick between cycles shows up as a stretched gap. It counts the strobes against the programmed count with surplus words in the FIFO, so an engine that drains the FIFO is caught. It starves a transfer mid-way to catch an engine that ends early or pops garbage. It also flushes the FIFO with soft reset and then sends one word, so stale data leaking through is caught, and it runs with enable low to catch an engine that ignores it.

// File: rtl/dbus_wr_ctrl.sv
module dbus_wr_ctrl #(
  parameter int          DW        = 16,
  parameter int          FDEPTH    = 8,
  parameter logic [31:0] COMP_CODE = 32'h0000_5A17,
  parameter logic [31:0] VERSION   = 32'h0003_0001,
  localparam int         FAW       = $clog2(FDEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic [DW-1:0] bus_data,
  output logic          bus_wr_n,
  output logic          bus_dc
);

  typedef enum logic [1:0] {S_IDLE, S_STRB, S_HOLD} st_t;

  logic [3:0]  ctrl_q;
  logic [2:0]  div_f;
  logic [3:0]  tw0_f;
  logic [5:0]  tw1_f;
  logic [17:0] cnt_f;
  logic [9:0]  pick_f;
  logic [1:0]  idp;

  wire en_q   = ctrl_q[0];
  wire srst_q = ctrl_q[1];
  wire stop_q = ctrl_q[2];
  wire dsel_q = ctrl_q[3];

  logic unused_wbits;
  assign unused_wbits = ^reg_wdata[31:18];

  wire wr_id   = reg_wr && reg_addr == 3'd0;
  wire wr_ctrl = reg_wr && reg_addr == 3'd1;
  wire wr_fifo = reg_wr && reg_addr == 3'd5;
  wire start   = wr_ctrl && stop_q && !reg_wdata[2] && !reg_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 4'b0100;
      div_f  <= '0;
      tw0_f  <= '0;
      tw1_f  <= '0;
      cnt_f  <= '0;
      pick_f <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd1: ctrl_q <= reg_wdata[3:0];
        3'd2: begin
          div_f <= reg_wdata[2:0];
          tw0_f <= reg_wdata[7:4];
          tw1_f <= reg_wdata[13:8];
        end
        3'd3: cnt_f  <= reg_wdata[17:0];
        3'd4: pick_f <= reg_wdata[9:0];
        default: ;
      endcase
    end
  end

  // transmit FIFO
  logic [DW-1:0] mem [FDEPTH];
  logic [FAW-1:0] wp, rp;
  logic [FAW:0]   fcnt;
  logic           launch;

  wire f_empty = fcnt == '0;
  wire f_full  = fcnt == (FAW+1)'(FDEPTH);
  wire push    = wr_fifo && !f_full && !srst_q;

  always_ff @(posedge clk) if (push) mem[wp] <= reg_wdata[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else if (srst_q) begin
      wp <= '0; rp <= '0; fcnt <= '0;
    end else begin
      if (push)   wp <= (wp == FAW'(FDEPTH-1)) ? '0 : wp + 1'b1;
      if (launch) rp <= (rp == FAW'(FDEPTH-1)) ? '0 : rp + 1'b1;
      fcnt <= fcnt + (FAW+1)'(push) - (FAW+1)'(launch);
    end
  end

  // functional clock divider
  logic [2:0] divc;
  wire run  = en_q && !srst_q;
  wire tick = run && divc == div_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    divc <= '0;
    else if (!run || tick) divc <= '0;
    else           divc <= divc + 1'b1;
  end

  // cycle engine
  st_t         st;
  logic [5:0]  phc;
  logic [17:0] rem;
  logic        active;

  wire hold_end = st == S_HOLD && phc == '0;
  assign launch = tick && active && !f_empty && !stop_q &&
                  (st == S_IDLE || (hold_end && rem != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; phc <= '0; rem <= '0; active <= 1'b0;
      bus_wr_n <= 1'b1; bus_data <= '0; bus_dc <= 1'b0;
    end else if (srst_q) begin
      st <= S_IDLE; phc <= '0; active <= 1'b0; bus_wr_n <= 1'b1;
    end else begin
      if (launch) begin
        st       <= S_STRB;
        phc      <= {2'b00, tw0_f};
        bus_wr_n <= 1'b0;
        bus_data <= mem[rp];
        bus_dc   <= dsel_q;
        if (st == S_HOLD) rem <= rem - 1'b1;
      end else if (tick) begin
        case (st)
          S_STRB:
            if (phc == '0) begin
              st <= S_HOLD; phc <= tw1_f; bus_wr_n <= 1'b1;
            end else phc <= phc - 1'b1;
          S_HOLD:
            if (phc == '0) begin
              st <= S_IDLE;
              if (rem == '0) active <= 1'b0;
              else           rem <= rem - 1'b1;
            end else phc <= phc - 1'b1;
          default: ;
        endcase
      end
      if (start) begin
        active <= 1'b1;
        rem    <= cnt_f;
      end
    end
  end

  // register read port and identification sequence
  logic [31:0] id_val;
  always_comb
    case (idp)
      2'd0:    id_val = 32'h5555_5555;
      2'd1:    id_val = 32'hAAAA_AAAA;
      2'd2:    id_val = COMP_CODE;
      default: id_val = VERSION;
    endcase

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idp <= '0;
    else if (wr_id) idp <= '0;
    else if (reg_rd && reg_addr == 3'd0 && idp != 2'd3) idp <= idp + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd)
      case (reg_addr)
        3'd0: reg_rdata <= id_val;
        3'd1: reg_rdata <= {28'd0, ctrl_q};
        3'd2: reg_rdata <= {18'd0, tw1_f, tw0_f, 1'b0, div_f};
        3'd3: reg_rdata <= {14'd0, cnt_f};
        3'd4: reg_rdata <= {22'd0, pick_f};
        3'd6: reg_rdata <= {29'd0, f_full, f_empty, !active};
        default: reg_rdata <= '0;
      endcase
  end

endmodule

// File: rtl/dbus_wr_ctrl_chk.sv
module dbus_wr_ctrl_chk #(
  parameter int DW  = 16,
  parameter int FAW = 3,
  parameter int FDEPTH = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr_n,
  input logic [DW-1:0] bus_data,
  input logic          bus_dc,
  input logic          stop_q,
  input logic          srst_q,
  input logic          launch,
  input logic [FAW:0]  fcnt
);

  logic [9:0] lowc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          lowc <= '0;
    else if (bus_wr_n)   lowc <= '0;
    else if (lowc != 10'h3FF) lowc <= lowc + 1'b1;
  end

  assert_bus_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && $past(!bus_wr_n)) |-> ($stable(bus_data) && $stable(bus_dc)));

  assert_no_launch_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> !$past(stop_q));

  assert_no_pop_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> fcnt != '0);

  assert_fifo_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= (FAW+1)'(FDEPTH));

  assert_srst_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (bus_wr_n && fcnt == '0));

  assert_strobe_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lowc <= 10'd128);

endmodule

bind dbus_wr_ctrl dbus_wr_ctrl_chk #(.DW(DW), .FAW(FAW), .FDEPTH(FDEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr_n(bus_wr_n), .bus_data(bus_data),
  .bus_dc(bus_dc), .stop_q(stop_q), .srst_q(srst_q), .launch(launch), .fcnt(fcnt)
);

// File: tb/dbus_wr_ctrl_tb_top.sv
module dbus_wr_ctrl_tb_top;
  localparam int DW = 16;
  localparam logic [31:0] COMP = 32'h0000_5A17;
  localparam logic [31:0] VER  = 32'h0003_0001;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [DW-1:0] bus_data;
  logic bus_wr_n, bus_dc;

  always #2 clk = ~clk;

  dbus_wr_ctrl #(.DW(DW), .FDEPTH(8), .COMP_CODE(COMP), .VERSION(VER)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_data(bus_data),
    .bus_wr_n(bus_wr_n), .bus_dc(bus_dc));

  int total = 0, bad = 0;
  logic [DW:0] expq[$];
  int exp_low = 1, exp_high = 1;
  bit chk_gap = 0, first_pend = 1;
  int strobes = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  bit prev_wr = 1'b1;
  int lo_cnt = 0, hi_cnt = 0;
  logic [DW-1:0] cur_d;
  always @(negedge clk) if (rst_n) begin
    if (prev_wr && !bus_wr_n) begin
      strobes++;
      if (chk_gap && !first_pend) chk(hi_cnt == exp_high, "R4 gap", hi_cnt, exp_high);
      first_pend = 0;
      if (expq.size() == 0) chk(0, "R5 unexpected strobe", bus_data, 0);
      else begin
        logic [DW:0] e;
        e = expq.pop_front();
        chk(bus_data == e[DW-1:0], "R7 word order", bus_data, e[DW-1:0]);
        chk(bus_dc == e[DW], "R6 dc", bus_dc, e[DW]);
      end
      cur_d = bus_data;
      lo_cnt = 1;
    end else if (!bus_wr_n) begin
      lo_cnt++;
      if (bus_data != cur_d) chk(0, "R7 data unstable", bus_data, cur_d);
    end
    if (!prev_wr && bus_wr_n) begin
      chk(lo_cnt == exp_low, "R3 strobe width", lo_cnt, exp_low);
      hi_cnt = 1;
    end else if (bus_wr_n) hi_cnt++;
    prev_wr = bus_wr_n;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic push(input logic [DW-1:0] w, input bit dc);
    expq.push_back({dc, w});
    wr(3'd5, {16'd0, w});
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3'd6, s);
      if (s[0]) return;
    end
    chk(0, req, 0, 1);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v;
  int s0;
  initial begin
    wait_clk(3); rst_n = 1; wait_clk(2);
    // reset state
    rd(3'd6, v); chk(v == 32'h3, "R10 reset status", v, 3);
    rd(3'd1, v); chk(v == 32'h4, "R10 reset ctrl", v, 4);
    chk(bus_wr_n == 1'b1, "R9 strobe idle at reset", bus_wr_n, 1);

    // identification sequence
    wr(3'd0, 0);
    rd(3'd0, v); chk(v == 32'h5555_5555, "R1 sync0", v, 32'h5555_5555);
    rd(3'd0, v); chk(v == 32'hAAAA_AAAA, "R1 sync1", v, 32'hAAAA_AAAA);
    rd(3'd0, v); chk(v == COMP, "R1 comp", v, COMP);
    rd(3'd0, v); chk(v == VER, "R1 version", v, VER);
    rd(3'd0, v); chk(v == VER, "R1 version hold", v, VER);
    wr(3'd0, 0);
    rd(3'd0, v); chk(v == 32'h5555_5555, "R1 rewind", v, 32'h5555_5555);

    // readback
    wr(3'd4, {22'd0, 5'd3, 5'd15});
    rd(3'd4, v); chk(v == 32'h6F, "R12 pick", v, 32'h6F);
    wr(3'd2, 32'h0000_0327);
    rd(3'd2, v); chk(v == 32'h0000_0327, "R12 timing", v, 32'h327);
    wr(3'd3, 32'h0003_FFFF);
    rd(3'd3, v); chk(v == 32'h0003_FFFF, "R12 count", v, 32'h3FFFF);

    // transfer A: div 1, tw0=2, tw1=3, 4 cycles, data, 2 surplus words
    wr(3'd2, {18'd0, 6'd3, 4'd2, 1'b0, 3'd0});
    wr(3'd3, 3);
    wr(3'd1, 32'h5);
    push(16'h1111, 1); push(16'h2222, 1); push(16'h3333, 1); push(16'h4444, 1);
    wr(3'd5, 16'hDEAD); wr(3'd5, 16'hBEEF);
    exp_low = 3; exp_high = 4; chk_gap = 1; first_pend = 1; s0 = strobes;
    wr(3'd1, 32'h9);
    wait_idle("R5 transfer A end");
    wait_clk(10);
    chk(strobes - s0 == 4, "R5 cycle count", strobes - s0, 4);
    chk(expq.size() == 0, "R5 all sent", expq.size(), 0);
    rd(3'd6, v); chk(v == 32'h1, "R10 idle with words left", v, 1);

    // R9 flush
    wr(3'd1, 32'h7); wr(3'd1, 32'h5);
    rd(3'd6, v); chk(v == 32'h3, "R9 flush empties", v, 3);

    // transfer B: div 3, tw0=1, tw1=0, 2 cycles, command
    wr(3'd2, {18'd0, 6'd0, 4'd1, 1'b0, 3'd2});
    wr(3'd3, 1);
    push(16'hA5A5, 0); push(16'h5A5A, 0);
    exp_low = 6; exp_high = 3; first_pend = 1; s0 = strobes;
    wr(3'd1, 32'h1);
    wait_idle("R2 transfer B end");
    wait_clk(10);
    chk(strobes - s0 == 2, "R2 cycle count B", strobes - s0, 2);

    // largest timing: div 8, tw0=15, tw1=63
    wr(3'd1, 32'h5);
    wr(3'd2, {18'd0, 6'd63, 4'd15, 1'b0, 3'd7});
    push(16'h0F0F, 1); push(16'hF0F0, 1);
    exp_low = 128; exp_high = 512; first_pend = 1; s0 = strobes;
    wr(3'd1, 32'h9);
    wait_idle("R3 max transfer end");
    wait_clk(10);
    chk(strobes - s0 == 2, "R4 max cycle count", strobes - s0, 2);

    // pause on empty
    chk_gap = 0; exp_low = 3;
    wr(3'd1, 32'h5);
    wr(3'd2, {18'd0, 6'd1, 4'd2, 1'b0, 3'd0});
    wr(3'd3, 2);
    push(16'h0001, 1);
    s0 = strobes;
    wr(3'd1, 32'h9);
    wait_clk(40);
    rd(3'd6, v); chk(v == 32'h2, "R11 paused busy", v, 2);
    chk(strobes - s0 == 1, "R11 one sent", strobes - s0, 1);
    push(16'h0002, 1); push(16'h0003, 1);
    wait_idle("R11 resume end");
    wait_clk(10);
    chk(strobes - s0 == 3, "R11 resumed count", strobes - s0, 3);

    // stop holds engine
    wr(3'd1, 32'h5);
    wr(3'd3, 0);
    wr(3'd5, 16'h7777);
    s0 = strobes;
    wait_clk(100);
    chk(strobes == s0, "R8 stop holds", strobes - s0, 0);
    rd(3'd6, v); chk(v == 32'h1, "R8 stopped idle", v, 1);
    wr(3'd1, 32'h7); wr(3'd1, 32'h5);

    // enable low: armed but no ticks
    wr(3'd1, 32'h0);
    push(16'h4242, 0);
    s0 = strobes;
    wait_clk(60);
    chk(strobes == s0, "R9 enable low", strobes - s0, 0);
    wr(3'd1, 32'h1);
    wait_idle("R9 enable end");
    wait_clk(10);
    chk(strobes - s0 == 1, "R9 enable resumes", strobes - s0, 1);

    // soft reset ends a starved transfer
    wr(3'd1, 32'h5);
    wr(3'd3, 3);
    wr(3'd1, 32'h1);
    rd(3'd6, v); chk(v == 32'h2, "R10 busy empty", v, 2);
    wr(3'd1, 32'h3);
    wr(3'd1, 32'h1);
    rd(3'd6, v); chk(v == 32'h3, "R9 abort idle", v, 3);

    // stale words gone after flush
    wr(3'd1, 32'h5);
    wr(3'd5, 16'h9999); wr(3'd5, 16'h8888);
    wr(3'd1, 32'h7); wr(3'd1, 32'h5);
    wr(3'd3, 0);
    push(16'hC0DE, 1);
    s0 = strobes;
    wr(3'd1, 32'h9);
    wait_idle("R9 post flush end");
    wait_clk(10);
    chk(strobes - s0 == 1 && expq.size() == 0, "R9 post flush", strobes - s0, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule